// File: doc/BRIEF.md
# Majority-Combining LFSR Keystream Generator

This block produces a pseudo-random keystream, one bit per step request. Inside it runs an odd number of Fibonacci linear feedback shift registers. Their lengths are pairwise coprime and each is built on a primitive feedback polynomial. On every step the block takes the low bit of each register, counts the ones, and registers the majority value as the keystream bit. All registers then shift together. A stream built this way no longer follows the simple linear recurrence of any single register. Because the lengths are coprime and each register has maximal period, the joint sequence keeps the longest possible period.

Software or a controlling state machine loads all registers at once from a flat seed bus. A register whose seed is zero over its own length would lock up, so such a load is refused as a whole and an error flag is raised. Each length and tap set is a parameter. An even register count stops elaboration, because a tie vote would be possible.

The default build holds three registers of lengths 5, 7 and 11, built on x^5+x^2+1, x^7+x+1 and x^11+x^2+1. A five-register build adds lengths 13 and 17.

Top module: `maj_keystream_gen`

## Requirements
- R1: While reset is active and in the cycles that follow its release, `ks_o` is 0 and `seed_err_o` is 0. Every register starts from the all-ones value across its own length.
- R2: A cycle with `step_i` high and `load_i` low registers into `ks_o` the majority of the register low bits as they were before that cycle's shift. The value is 1 when more than half of those bits are 1. For three registers this equals (a&b)|(a&c)|(b&c).
- R3: On a step, every register shifts right by one position. Its new top bit is the XOR of the state bits that its tap mask selects, where mask bit j selects state bit j. Bit 0 is always selected. Default masks: 5'h05, 7'h03, 11'h005.
- R4: A cycle with both `step_i` and `load_i` low leaves `ks_o`, `seed_err_o` and every register state unchanged.
- R5: Register i takes its seed from `seed_i[i*SEED_W +: LEN_i]`, and bits above LEN_i are ignored. If every such slice is nonzero, `load_i` writes all registers in the same cycle and clears `seed_err_o`. `ks_o` keeps its value.
- R6: If any slice is zero, `load_i` changes no register, sets `seed_err_o` and keeps `ks_o`.
- R7: When `load_i` and `step_i` are high in the same cycle, the load takes effect and the step is dropped: no shift happens and `ks_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Produce one keystream bit and advance all registers |
| load_i | input | 1 | Load all registers from `seed_i` at once |
| seed_i | input | NREG*SEED_W | Seeds; register i uses the low LEN_i bits of slice i |
| ks_o | output | 1 | Registered keystream bit |
| seed_err_o | output | 1 | Set by a refused load, cleared by an accepted load |

## Verification
The bench aims at the vote boundary, where exactly two of the three low bits are set. A design that used XOR, or counted with a threshold off by one, would give the wrong bit there. Seeds that are zero in only one register's own bits, with noise in the unused upper bits, are also covered. These catch a zero check that looks at the wrong width: such a design would either accept a lock-up seed or refuse a valid one. A load and a step in the same cycle, followed by a long run of steps, would show a step that leaked through or a load applied to only some registers. Idle cycles placed between steps would show an output that moved without a step.

// File: rtl/maj_lfsr_pkg.sv
package maj_lfsr_pkg;

  // Per-cycle action decided from the control inputs.
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STEP   = 2'd1,
    OP_LOAD   = 2'd2,
    OP_REJECT = 2'd3
  } lfsr_op_e;

  localparam int unsigned LEN_FIELD_W = 8;

endpackage

// File: rtl/lfsr_cell.sv
module lfsr_cell #(
  parameter int unsigned      LEN  = 5,
  parameter logic [LEN-1:0]   MASK = 5'h05
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           load_en,
  input  logic [LEN-1:0] seed,
  output logic           lsb_o,
  output logic [LEN-1:0] state_o
);

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_d;
  logic           fb;

  always_comb begin
    fb      = ^(state_q & MASK);
    state_d = state_q;
    if (load_en) begin
      state_d = seed;
    end else if (shift_en) begin
      state_d = {fb, state_q[LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
    end else if (load_en || shift_en) begin
      state_q <= state_d;
    end
  end

  assign lsb_o   = state_q[0];
  assign state_o = state_q;

endmodule

// File: rtl/seed_guard.sv
module seed_guard #(
  parameter int unsigned              NREG    = 3,
  parameter int unsigned              SEED_W  = 17,
  parameter logic [NREG*8-1:0]        LEN_VEC = {8'd11, 8'd7, 8'd5}
) (
  input  logic [NREG*SEED_W-1:0] seeds,
  output logic                   zero_any
);

  logic [NREG-1:0] zero_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_zchk
    localparam int unsigned L = LEN_VEC[i*8 +: 8];
    assign zero_vec[i] = (seeds[i*SEED_W +: L] == '0);
  end

  assign zero_any = |zero_vec;

endmodule

// File: rtl/maj_vote.sv
module maj_vote #(
  parameter int unsigned NREG = 3
) (
  input  logic [NREG-1:0] bits,
  output logic            maj
);

  localparam int unsigned CW   = $clog2(NREG + 1);
  localparam int unsigned HALF = NREG / 2;

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CW'(bits[i]);
    end
    maj = (cnt > CW'(HALF));
  end

endmodule

// File: rtl/maj_keystream_gen.sv
module maj_keystream_gen
  import maj_lfsr_pkg::*;
#(
  parameter int unsigned          NREG    = 3,
  parameter int unsigned          SEED_W  = 17,
  parameter logic [NREG*8-1:0]    LEN_VEC = {8'd11, 8'd7, 8'd5},
  parameter logic [NREG*SEED_W-1:0] TAP_VEC = {17'h00005, 17'h00003, 17'h00005}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_i,
  input  logic                   load_i,
  input  logic [NREG*SEED_W-1:0] seed_i,
  output logic                   ks_o,
  output logic                   seed_err_o
);

  // An even count could tie the vote: refuse it at elaboration.
  if ((NREG % 2) == 0) begin : g_even_count
    $error("maj_keystream_gen: register count must be odd");
  end

  // Reset synchronizer: asserts at once, releases on the clock.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                   zero_any;
  lfsr_op_e               op;
  logic [NREG-1:0]        lsb_vec;
  logic [NREG*SEED_W-1:0] state_flat;
  logic                   vote;
  logic                   ks_d, err_d;

  seed_guard #(
    .NREG(NREG), .SEED_W(SEED_W), .LEN_VEC(LEN_VEC)
  ) u_guard (
    .seeds(seed_i), .zero_any(zero_any)
  );

  always_comb begin
    if (load_i) begin
      op = zero_any ? OP_REJECT : OP_LOAD;
    end else if (step_i) begin
      op = OP_STEP;
    end else begin
      op = OP_IDLE;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int unsigned  L = LEN_VEC[i*8 +: 8];
    localparam logic [L-1:0] M = TAP_VEC[i*SEED_W +: L];
    logic [L-1:0] st;

    lfsr_cell #(.LEN(L), .MASK(M)) u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .shift_en(op == OP_STEP),
      .load_en (op == OP_LOAD),
      .seed    (seed_i[i*SEED_W +: L]),
      .lsb_o   (lsb_vec[i]),
      .state_o (st)
    );

    assign state_flat[i*SEED_W +: L] = st;
    if (L < SEED_W) begin : g_pad
      assign state_flat[i*SEED_W + L +: SEED_W - L] = '0;
    end
  end

  maj_vote #(.NREG(NREG)) u_vote (.bits(lsb_vec), .maj(vote));

  always_comb begin
    ks_d  = ks_o;
    err_d = seed_err_o;
    case (op)
      OP_STEP:   ks_d  = vote;
      OP_LOAD:   err_d = 1'b0;
      OP_REJECT: err_d = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ks_o       <= 1'b0;
      seed_err_o <= 1'b0;
    end else if (op != OP_IDLE) begin
      ks_o       <= ks_d;
      seed_err_o <= err_d;
    end
  end

endmodule

// File: rtl/maj_lfsr_chk.sv
module maj_lfsr_chk #(
  parameter int unsigned NREG   = 3,
  parameter int unsigned SEED_W = 17
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   step_i,
  input logic                   load_i,
  input logic                   zero_any,
  input logic [NREG-1:0]        lsb_vec,
  input logic [NREG*SEED_W-1:0] state_flat,
  input logic                   ks_o,
  input logic                   seed_err_o
);

  // R2
  maj_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !load_i) |=> (ks_o == ($countones($past(lsb_vec)) > (NREG / 2))));

  // R3
  for (genvar i = 0; i < NREG; i++) begin : g_shift
    shift_right_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (step_i && !load_i) |=> (lsb_vec[i] == $past(state_flat[i*SEED_W + 1])));
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_i && !load_i) |=> ($stable(ks_o) && $stable(seed_err_o) && $stable(state_flat)));

  // R5
  load_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && !zero_any) |=> (!seed_err_o && $stable(ks_o)));

  // R6
  load_refuse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && zero_any) |=> (seed_err_o && $stable(ks_o) && $stable(state_flat)));

endmodule

bind maj_keystream_gen maj_lfsr_chk #(.NREG(NREG), .SEED_W(SEED_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .step_i    (step_i),
  .load_i    (load_i),
  .zero_any  (zero_any),
  .lsb_vec   (lsb_vec),
  .state_flat(state_flat),
  .ks_o      (ks_o),
  .seed_err_o(seed_err_o)
);

// File: tb/maj_keystream_gen_tb.sv
module maj_keystream_gen_tb;

  localparam int unsigned NR = 3;
  localparam int unsigned SW = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              step_i, load_i;
  logic [NR*SW-1:0]  seed_i;
  logic              ks_o, seed_err_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  int unsigned m_len  [NR] = '{5, 7, 11};
  logic [SW-1:0] m_mask [NR] = '{17'h05, 17'h03, 17'h005};
  logic [SW-1:0] m_st   [NR];
  logic          m_ks, m_err;

  always #5 clk = ~clk;

  maj_keystream_gen u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .load_i(load_i),
    .seed_i(seed_i), .ks_o(ks_o), .seed_err_o(seed_err_o)
  );

  function automatic logic [SW-1:0] lenmask(int unsigned l);
    return SW'((1 << l) - 1);
  endfunction

  function automatic logic [NR*SW-1:0] pack3(logic [SW-1:0] a, logic [SW-1:0] b,
                                             logic [SW-1:0] c);
    return {c, b, a};
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Model of one cycle, written from the requirements.
  task automatic model_cycle(logic s, logic l, logic [NR*SW-1:0] sd);
    logic zero;
    int   ones;
    zero = 1'b0;
    for (int i = 0; i < NR; i++)
      if ((sd[i*SW +: SW] & lenmask(m_len[i])) == '0) zero = 1'b1;
    if (l) begin
      if (zero) m_err = 1'b1;
      else begin
        m_err = 1'b0;
        for (int i = 0; i < NR; i++) m_st[i] = sd[i*SW +: SW] & lenmask(m_len[i]);
      end
    end else if (s) begin
      ones = 0;
      for (int i = 0; i < NR; i++) ones += int'(m_st[i][0]);
      m_ks = (ones > NR / 2);
      for (int i = 0; i < NR; i++) begin
        logic fb;
        fb = ^(m_st[i] & m_mask[i]);
        m_st[i] = (m_st[i] >> 1) | (SW'(fb) << (m_len[i] - 1));
      end
    end
  endtask

  task automatic cyc(string req, logic s, logic l, logic [NR*SW-1:0] sd);
    step_i = s; load_i = l; seed_i = sd;
    @(posedge clk);
    model_cycle(s, l, sd);
    @(negedge clk);
    step_i = 1'b0; load_i = 1'b0;
    check(req, ks_o, m_ks);
    check(req, seed_err_o, m_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    rst_n = 1'b0; step_i = 1'b0; load_i = 1'b0; seed_i = '0;
    for (int i = 0; i < NR; i++) m_st[i] = lenmask(m_len[i]);
    m_ks = 1'b0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ks in reset", ks_o, 1'b0);
    check("R1 err in reset", seed_err_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ks after release", ks_o, 1'b0);
    check("R1 err after release", seed_err_o, 1'b0);

    // All-ones start: first vote is 1, then follow the stream.
    cyc("R1 first step from all-ones", 1'b1, 1'b0, '0);
    check("R1 first bit literal", ks_o, 1'b1);
    for (int k = 0; k < 40; k++) cyc("R3 stream from reset", 1'b1, 1'b0, '0);

    // Vote boundaries: exactly one and exactly two low bits set.
    cyc("R5 load 1,0,0", 1'b0, 1'b1, pack3(17'h01, 17'h02, 17'h002));
    cyc("R2 one of three", 1'b1, 1'b0, '0);
    check("R2 one of three literal", ks_o, 1'b0);
    cyc("R5 load 1,1,0", 1'b0, 1'b1, pack3(17'h01, 17'h03, 17'h004));
    cyc("R2 two of three", 1'b1, 1'b0, '0);
    check("R2 two of three literal", ks_o, 1'b1);
    cyc("R5 load 0,1,1", 1'b0, 1'b1, pack3(17'h02, 17'h01, 17'h001));
    cyc("R2 two of three other", 1'b1, 1'b0, '0);
    cyc("R5 load 0,0,0 low bits", 1'b0, 1'b1, pack3(17'h02, 17'h02, 17'h002));
    cyc("R2 none set", 1'b1, 1'b0, '0);

    // Idle cycles between steps.
    for (int k = 0; k < 4; k++) cyc("R4 idle hold", 1'b0, 1'b0, '0);
    for (int k = 0; k < 10; k++) cyc("R4 resume after idle", 1'b1, 1'b0, '0);

    // Zero only inside register 1's own length, noise above it.
    cyc("R6 refuse zero slice", 1'b0, 1'b1, pack3(17'h1F, 17'h1FF80, 17'h3));
    check("R6 err literal", seed_err_o, 1'b1);
    for (int k = 0; k < 20; k++) cyc("R6 state kept", 1'b1, 1'b0, '0);
    // Upper noise with nonzero low bits is accepted.
    cyc("R5 accept with noise", 1'b0, 1'b1, pack3(17'h1FFE1, 17'h1FF81, 17'h1F801));
    check("R5 err cleared literal", seed_err_o, 1'b0);
    for (int k = 0; k < 20; k++) cyc("R5 stream after seed", 1'b1, 1'b0, '0);

    // Load and step together.
    cyc("R7 load wins over step", 1'b1, 1'b1, pack3(17'h15, 17'h2A, 17'h555));
    for (int k = 0; k < 300; k++) cyc("R7 stream from seed", 1'b1, 1'b0, '0);

    // Constrained random mix.
    for (int k = 0; k < 4000; k++) begin
      logic [NR*SW-1:0] sd;
      logic s, l;
      for (int i = 0; i < NR; i++)
        sd[i*SW +: SW] = (($urandom % 4) == 0) ? SW'($urandom) & ~lenmask(m_len[i])
                                               : SW'($urandom);
      s = (($urandom % 10) < 7);
      l = (($urandom % 20) == 0);
      cyc(l ? "R5 R6 R7 random load" : (s ? "R2 R3 random step" : "R4 random idle"),
          s, l, sd);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule